// File: doc/BRIEF.md
# Shutdown / Output-Enable Pin Resolver

This block takes one asynchronous control pin plus a set of configuration bits and decides, for every clock output of a clock generator, whether its driver is tri-stated, running, or parked at a fixed level. A global role bit chooses what the pin does. It can be a chip-wide shutdown request, or it can be an enable that each output may or may not listen to. A polarity bit chooses which pin level enables the outputs.

The pin first passes through a two-flop synchronizer in the core clock domain. Every output state is then a combinational function of the synchronized pin and the live configuration bits. Each output has three per-output bits: one that powers its output stage, one that makes it follow the pin, and one that marks the driver as differential or single-ended. The last bit sets the level the output takes when parked.

Top module: `sdoe_ctrl`

## Requirements
- R1: While rst_ni is low, the synchronized pin is held at 0, so glb_sd_o is 0 whatever ctl_pin_i is.
- R2: A change on ctl_pin_i first affects the outputs after exactly two rising clock edges, not after one.
- R3: The enabling level of the pin equals pol_i. A synchronized pin level different from pol_i is the disabling level.
- R4: When sd_mode_i is 1 and the synchronized pin is 1, glb_sd_o is 1 and every output's state is parked (2'b10), regardless of its per-output bits and of pol_i.
- R5: glb_sd_o is 0 whenever sd_mode_i is 0 or the synchronized pin is 0.
- R6: When global shutdown is not in force and pwr_en_i[k] is 0, output k is tri-state (2'b00), regardless of pin_sens_i[k] and the pin.
- R7: When global shutdown is not in force, pwr_en_i[k] is 1 and pin_sens_i[k] is 0, output k is active (2'b01) at any pin level.
- R8: When global shutdown is not in force and both pwr_en_i[k] and pin_sens_i[k] are 1, output k is parked (2'b10) while the synchronized pin is at its disabling level and active (2'b01) otherwise. This holds in both roles of the pin.
- R9: A parked differential output (diff_i[k]=1) drives lvl_p_o[k]=1 and lvl_n_o[k]=0. A parked single-ended output (diff_i[k]=0) drives both low. A non-parked output drives both level bits low.
- R10: Output k's state sits in state_o[2k+1:2k] and is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_pin_i | input | 1 | Asynchronous shutdown/enable pin |
| sd_mode_i | input | 1 | 1: pin is global shutdown; 0: pin is output enable |
| pol_i | input | 1 | Enabling level of the pin |
| pwr_en_i | input | NUM_OUT | Per-output stage power enable |
| pin_sens_i | input | NUM_OUT | Per-output sensitivity to the pin |
| diff_i | input | NUM_OUT | Per-output driver type, 1 = differential |
| state_o | output | 2*NUM_OUT | Per-output state: 00 tri-state, 01 active, 10 parked |
| lvl_p_o | output | NUM_OUT | Parked level of the positive leg |
| lvl_n_o | output | NUM_OUT | Parked level of the negative leg |
| glb_sd_o | output | 1 | Global shutdown in force |

## Verification
The assertions assume that the configuration inputs are synchronous to clk_i and settle between edges. They also assume that only ctl_pin_i arrives asynchronously. The bench respects this by changing every input on the falling edge, the pin included, so the synchronizer sees no metastable sample. A behavioural model tracks the two pin delays on its own. Configuration bits change rarely and the pin toggles often, so all roles, polarities and per-output combinations occur with both pin levels.

// File: rtl/sdoe_pkg.sv
package sdoe_pkg;
  typedef enum logic [1:0] {
    OS_TRI  = 2'b00,
    OS_ACT  = 2'b01,
    OS_PARK = 2'b10
  } out_state_e;
endpackage

// File: rtl/sdoe_sync.sv
module sdoe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/sdoe_pin_decode.sv
module sdoe_pin_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic sd_mode_i,
  input  logic pol_i,
  output logic glb_sd_o,
  output logic park_req_o
);
  // pin away from its enabling level requests parking
  assign glb_sd_o   = sd_mode_i & pin_s_i;
  assign park_req_o = pin_s_i ^ pol_i;

  a_r4_sd_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_sd_o |-> sd_mode_i);
  a_r5_sd_needs_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_sd_o |-> pin_s_i);
endmodule

// File: rtl/sdoe_out_gate.sv
module sdoe_out_gate
  import sdoe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       glb_sd_i,
  input  logic       park_req_i,
  input  logic       pwr_en_i,
  input  logic       pin_sens_i,
  input  logic       diff_i,
  output logic [1:0] state_o,
  output logic       lvl_p_o,
  output logic       lvl_n_o
);
  out_state_e st;

  always_comb begin
    if (glb_sd_i)                      st = OS_PARK;
    else if (!pwr_en_i)                st = OS_TRI;
    else if (pin_sens_i && park_req_i) st = OS_PARK;
    else                               st = OS_ACT;
  end

  assign state_o = st;
  assign lvl_p_o = (st == OS_PARK) & diff_i;
  assign lvl_n_o = 1'b0;

  a_r10_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);
  a_r9_idle_levels_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != OS_PARK) |-> (!lvl_p_o && !lvl_n_o));
  a_r6_unpowered_tri: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_sd_i && !pwr_en_i) |-> (state_o == OS_TRI));
  a_r7_insensitive_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_sd_i && pwr_en_i && !pin_sens_i) |-> (state_o == OS_ACT));
  a_r4_shutdown_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_sd_i |-> (state_o == OS_PARK));
endmodule

// File: rtl/sdoe_ctrl.sv
module sdoe_ctrl #(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctl_pin_i,
  input  logic                 sd_mode_i,
  input  logic                 pol_i,
  input  logic [NUM_OUT-1:0]   pwr_en_i,
  input  logic [NUM_OUT-1:0]   pin_sens_i,
  input  logic [NUM_OUT-1:0]   diff_i,
  output logic [2*NUM_OUT-1:0] state_o,
  output logic [NUM_OUT-1:0]   lvl_p_o,
  output logic [NUM_OUT-1:0]   lvl_n_o,
  output logic                 glb_sd_o
);
  logic pin_s;
  logic park_req;

  sdoe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_pin_i),
    .q_o   (pin_s)
  );

  sdoe_pin_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_s_i   (pin_s),
    .sd_mode_i (sd_mode_i),
    .pol_i     (pol_i),
    .glb_sd_o  (glb_sd_o),
    .park_req_o(park_req)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    sdoe_out_gate u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .glb_sd_i  (glb_sd_o),
      .park_req_i(park_req),
      .pwr_en_i  (pwr_en_i[k]),
      .pin_sens_i(pin_sens_i[k]),
      .diff_i    (diff_i[k]),
      .state_o   (state_o[2*k+1:2*k]),
      .lvl_p_o   (lvl_p_o[k]),
      .lvl_n_o   (lvl_n_o[k])
    );
  end
endmodule

// File: tb/tb_sdoe_ctrl.sv
module tb_sdoe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int CYCLES = 3000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ctl_pin_i = 1'b0;
  logic sd_mode_i = 1'b0;
  logic pol_i = 1'b0;
  logic [N-1:0] pwr_en_i = '0;
  logic [N-1:0] pin_sens_i = '0;
  logic [N-1:0] diff_i = '0;
  logic [2*N-1:0] state_o;
  logic [N-1:0] lvl_p_o, lvl_n_o;
  logic glb_sd_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit m_s1 = 1'b0, m_s2 = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdoe_ctrl #(.NUM_OUT(N)) dut (.*);

  // reference pin delay line
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin m_s1 = 1'b0; m_s2 = 1'b0; end
    else begin m_s2 = m_s1; m_s1 = ctl_pin_i; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit gsd, dis;
    gsd = sd_mode_i && m_s2;
    dis = (m_s2 != pol_i);
    chk(glb_sd_o == gsd, gsd ? "R4" : "R5", glb_sd_o, gsd);
    for (int k = 0; k < N; k++) begin
      int exp_st;
      string tag;
      bit parked;
      if (gsd)                            begin exp_st = 2; tag = "R4"; end
      else if (!pwr_en_i[k])              begin exp_st = 0; tag = "R6"; end
      else if (!pin_sens_i[k])            begin exp_st = 1; tag = "R7"; end
      else if (dis)                       begin exp_st = 2; tag = "R8"; end
      else                                begin exp_st = 1; tag = "R3"; end
      parked = (exp_st == 2);
      chk(state_o[2*k +: 2] != 2'b11, "R10", state_o[2*k +: 2], exp_st);
      chk(state_o[2*k +: 2] == exp_st, tag, state_o[2*k +: 2], exp_st);
      chk(lvl_p_o[k] == (parked && diff_i[k]), "R9", lvl_p_o[k], parked && diff_i[k]);
      chk(lvl_n_o[k] == 1'b0, "R9", lvl_n_o[k], 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    err_cnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    // R1: pin high under reset must not reach the shutdown flag
    sd_mode_i = 1'b1; ctl_pin_i = 1'b1; pwr_en_i = '1;
    repeat (3) @(negedge clk_i);
    chk(glb_sd_o == 1'b0, "R1", glb_sd_o, 0);
    chk(state_o[1:0] == 2'b01, "R1", state_o[1:0], 1);
    ctl_pin_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2: two-edge latency of the pin
    ctl_pin_i = 1'b1;
    @(negedge clk_i);
    chk(glb_sd_o == 1'b0, "R2", glb_sd_o, 0);
    @(negedge clk_i);
    chk(glb_sd_o == 1'b1, "R2", glb_sd_o, 1);
    ctl_pin_i = 1'b0;
    @(negedge clk_i);
    chk(glb_sd_o == 1'b1, "R2", glb_sd_o, 1);
    @(negedge clk_i);
    chk(glb_sd_o == 1'b0, "R2", glb_sd_o, 0);

    // R3/R8: enable-pin role, both polarities, all outputs listening
    sd_mode_i = 1'b0; pin_sens_i = '1; diff_i = 4'b0101;
    for (int p = 0; p < 2; p++) begin
      pol_i = p[0];
      for (int lv = 0; lv < 2; lv++) begin
        ctl_pin_i = lv[0];
        repeat (2) @(negedge clk_i);
        compare_all();
      end
    end

    // mixed stimulus: pin toggles often, configuration rarely
    for (int c = 0; c < CYCLES; c++) begin
      compare_all();
      ctl_pin_i = $urandom_range(1, 0) == 1;
      if ($urandom_range(7, 0) == 0) begin
        sd_mode_i  = $urandom_range(1, 0) == 1;
        pol_i      = $urandom_range(1, 0) == 1;
        pwr_en_i   = N'($urandom);
        pin_sens_i = N'($urandom);
        diff_i     = N'($urandom);
      end
      @(negedge clk_i);
    end
    compare_all();

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule